// File: doc/BRIEF.md
# Dual-Memory Bus Control Decoder

This block sits behind the shared pins of a package that stacks a flash array and a static RAM on one address and data bus. Each clock it samples the control pins: the flash enable, the RAM select pair, output enable, write enable, flash reset, the two width-configuration inputs and the RAM byte enables. From them it produces one read and one write strobe per device, a standby flag, a flag for the forbidden state where both devices are selected, RAM byte-lane enables and a per-pin output-enable vector for the data bus.

When the flash is configured for byte lanes, only the low lane carries data. The upper lane pins are held in high impedance, and the top data pin becomes an extra address input below the normal address bits. The decoder captures that pin as a low address bit. The RAM keeps its own byte-lane enables whatever width the flash uses.

Every output is registered, so each result appears one clock after the pins that cause it. A system integrator places the block between the pad ring and the two memory controllers.

Top module: `mcp_bus_decoder`

## Requirements
- R1: A flash read strobe (`fl_rd`=1) is produced when `fl_ce_n`=0, `oe_n`=0, `we_n`=1 and `fl_rst_n`=1, and the RAM is not selected.
- R2: A flash write strobe (`fl_wr`=1) is produced when `fl_ce_n`=0, `we_n`=0, `oe_n`=1 and `fl_rst_n`=1, and the RAM is not selected. `fl_rd` and `fl_wr` are never both 1.
- R3: The RAM counts as selected only when `ram_sel_n`=0 and `ram_sel_hi`=1. When the RAM is selected and the flash is not, `ram_rd`=1 for `oe_n`=0 and `we_n`=1, and `ram_wr`=1 for `we_n`=0 whatever the value of `oe_n`.
- R4: During a flash read with `fl_word`=1, all `DATA_W` bits of `dq_oe` are 1. During a flash read with `fl_word`=0, only the low lane (bits 0 to 7 by default) is 1.
- R5: While the flash is selected, out of reset, not in conflict and `fl_word`=0, `addr_lsb_vld`=1 and `addr_lsb` equals `dq15_in`. Otherwise both are 0.
- R6: With the RAM selected and `ram_word`=1, `ram_lo_en`=!`ram_lb_n` and `ram_hi_en`=!`ram_ub_n`. With `ram_word`=0, `ram_lo_en`=1 and `ram_hi_en`=0, and the byte enables have no effect. During a RAM read, the low-lane bits of `dq_oe` follow `ram_lo_en` and the upper-lane bits follow `ram_hi_en`.
- R7: With `oe_n`=1, every bit of `dq_oe` is 0.
- R8: With `fl_rst_n`=0, `fl_rd`, `fl_wr` and `addr_lsb_vld` are 0, and the flash drives no `dq_oe` bit.
- R9: With `fl_ce_n`=0 and the RAM selected at the same time, `sel_conflict`=1, no read or write strobe is raised and `dq_oe` is all 0.
- R10: `standby`=1 exactly when neither the flash nor the RAM is selected.
- R11: Every output changes one clock after its inputs. While `rst_n`=0, all outputs are 0 except `standby`, which is 1.
- R12: `fl_rd` and `ram_rd` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| fl_ce_n | input | 1 | Flash enable, active low |
| ram_sel_n | input | 1 | RAM select, active low |
| ram_sel_hi | input | 1 | RAM select, active high |
| oe_n | input | 1 | Shared output enable, active low |
| we_n | input | 1 | Shared write enable, active low |
| fl_rst_n | input | 1 | Flash hardware reset, active low |
| fl_word | input | 1 | Flash width: 1 selects word lanes, 0 selects byte lanes |
| ram_word | input | 1 | RAM width: 1 selects word lanes, 0 selects byte lanes |
| ram_lb_n | input | 1 | RAM low byte enable, active low |
| ram_ub_n | input | 1 | RAM high byte enable, active low |
| dq15_in | input | 1 | Level sampled on the top data pin |
| fl_rd | output | 1 | Flash read strobe |
| fl_wr | output | 1 | Flash write strobe |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| standby | output | 1 | Neither device is selected |
| sel_conflict | output | 1 | Both devices are selected (forbidden state) |
| ram_lo_en | output | 1 | RAM low byte lane active |
| ram_hi_en | output | 1 | RAM high byte lane active |
| addr_lsb | output | 1 | Extra low address bit in flash byte mode |
| addr_lsb_vld | output | 1 | `addr_lsb` is meaningful |
| dq_oe | output | DATA_W | Per-pin drive enable for the data bus |

## Verification
Two protections can apply in the same cycle: the flash reset hold-off and the dual-select conflict guard. Both silence the flash, but only the conflict guard also silences the RAM. The bench sweeps every combination of the eleven control pins, so the cycles where `fl_rst_n`=0 and a RAM select land on top of `fl_ce_n`=0 are all covered. A behavioural model then judges each one, and it expects the conflict flag, a quiet bus and no strobes for both devices. Directed steps add the case of a flash byte-mode read taken in the same cycle as a reset, where `addr_lsb_vld` must drop even though `fl_word`=0.

// File: rtl/mcp_bus_pkg.sv
package mcp_bus_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_FLASH = 2'd1,
    OWN_RAM   = 2'd2
  } bus_owner_e;

  // RAM needs both select polarities active.
  function automatic logic ram_is_selected(input logic sel_n, input logic sel_hi);
    return (~sel_n) & sel_hi;
  endfunction

  // Flash pin drive during a read: low lane always, upper pins only in word mode.
  function automatic logic flash_pin_drive(input logic low_lane, input logic word_mode);
    return low_lane | word_mode;
  endfunction

  // RAM pin drive during a read: each lane follows its byte enable.
  function automatic logic ram_pin_drive(input logic low_lane, input logic lo_en,
                                         input logic hi_en);
    return low_lane ? lo_en : hi_en;
  endfunction

endpackage

// File: rtl/mcp_select_dec.sv
module mcp_select_dec
  import mcp_bus_pkg::*;
(
  input  logic fl_ce_n,
  input  logic ram_sel_n,
  input  logic ram_sel_hi,
  input  logic fl_rst_n,
  output logic fl_go,
  output logic ram_go,
  output logic conflict,
  output logic idle
);
  logic fl_sel;
  logic ram_sel;

  always_comb begin
    fl_sel   = ~fl_ce_n;
    ram_sel  = ram_is_selected(ram_sel_n, ram_sel_hi);
    conflict = fl_sel & ram_sel;
    idle     = ~fl_sel & ~ram_sel;
    // Flash proceeds only out of reset and without a competing select.
    fl_go    = fl_sel & fl_rst_n & ~conflict;
    ram_go   = ram_sel & ~conflict;
  end
endmodule

// File: rtl/mcp_access_dec.sv
module mcp_access_dec
  import mcp_bus_pkg::*;
(
  input  logic       fl_go,
  input  logic       ram_go,
  input  logic       oe_n,
  input  logic       we_n,
  output logic       fl_rd,
  output logic       fl_wr,
  output logic       ram_rd,
  output logic       ram_wr,
  output bus_owner_e owner
);
  logic rd_phase;
  logic fl_wr_phase;

  always_comb begin
    rd_phase    = ~oe_n & we_n;
    fl_wr_phase = ~we_n & oe_n;
    fl_rd       = fl_go & rd_phase;
    fl_wr       = fl_go & fl_wr_phase;
    ram_rd      = ram_go & rd_phase;
    ram_wr      = ram_go & ~we_n;
    if (fl_rd)       owner = OWN_FLASH;
    else if (ram_rd) owner = OWN_RAM;
    else             owner = OWN_NONE;
  end
endmodule

// File: rtl/mcp_lane_ctrl.sv
module mcp_lane_ctrl
  import mcp_bus_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LANE_W = DATA_W / 2
) (
  input  bus_owner_e        owner,
  input  logic              fl_go,
  input  logic              ram_go,
  input  logic              fl_word,
  input  logic              ram_word,
  input  logic              ram_lb_n,
  input  logic              ram_ub_n,
  input  logic              dq15_in,
  output logic              ram_lo_en,
  output logic              ram_hi_en,
  output logic              addr_lsb,
  output logic              addr_lsb_vld,
  output logic [DATA_W-1:0] dq_oe
);
  always_comb begin
    if (!ram_go) begin
      ram_lo_en = 1'b0;
      ram_hi_en = 1'b0;
    end else if (ram_word) begin
      ram_lo_en = ~ram_lb_n;
      ram_hi_en = ~ram_ub_n;
    end else begin
      ram_lo_en = 1'b1;
      ram_hi_en = 1'b0;
    end
    addr_lsb_vld = fl_go & ~fl_word;
    addr_lsb     = addr_lsb_vld & dq15_in;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_pin
    localparam logic IS_LOW = (i < LANE_W);
    always_comb begin
      unique case (owner)
        OWN_FLASH: dq_oe[i] = flash_pin_drive(IS_LOW, fl_word);
        OWN_RAM:   dq_oe[i] = ram_pin_drive(IS_LOW, ram_lo_en, ram_hi_en);
        default:   dq_oe[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mcp_bus_decoder.sv
module mcp_bus_decoder
  import mcp_bus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fl_ce_n,
  input  logic              ram_sel_n,
  input  logic              ram_sel_hi,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              fl_rst_n,
  input  logic              fl_word,
  input  logic              ram_word,
  input  logic              ram_lb_n,
  input  logic              ram_ub_n,
  input  logic              dq15_in,
  output logic              fl_rd,
  output logic              fl_wr,
  output logic              ram_rd,
  output logic              ram_wr,
  output logic              standby,
  output logic              sel_conflict,
  output logic              ram_lo_en,
  output logic              ram_hi_en,
  output logic              addr_lsb,
  output logic              addr_lsb_vld,
  output logic [DATA_W-1:0] dq_oe
);
  localparam int LANE_W = DATA_W / 2;

  // Named internal events, visible to the assertions.
  logic       fl_go, ram_go, conflict_c, idle_c;
  logic       fl_rd_c, fl_wr_c, ram_rd_c, ram_wr_c;
  logic       lo_en_c, hi_en_c, lsb_c, lsb_vld_c;
  logic [DATA_W-1:0] oe_c;
  bus_owner_e owner_c;

  mcp_select_dec u_sel (
    .fl_ce_n   (fl_ce_n),
    .ram_sel_n (ram_sel_n),
    .ram_sel_hi(ram_sel_hi),
    .fl_rst_n  (fl_rst_n),
    .fl_go     (fl_go),
    .ram_go    (ram_go),
    .conflict  (conflict_c),
    .idle      (idle_c)
  );

  mcp_access_dec u_acc (
    .fl_go (fl_go),
    .ram_go(ram_go),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .fl_rd (fl_rd_c),
    .fl_wr (fl_wr_c),
    .ram_rd(ram_rd_c),
    .ram_wr(ram_wr_c),
    .owner (owner_c)
  );

  mcp_lane_ctrl #(.DATA_W(DATA_W)) u_lane (
    .owner       (owner_c),
    .fl_go       (fl_go),
    .ram_go      (ram_go),
    .fl_word     (fl_word),
    .ram_word    (ram_word),
    .ram_lb_n    (ram_lb_n),
    .ram_ub_n    (ram_ub_n),
    .dq15_in     (dq15_in),
    .ram_lo_en   (lo_en_c),
    .ram_hi_en   (hi_en_c),
    .addr_lsb    (lsb_c),
    .addr_lsb_vld(lsb_vld_c),
    .dq_oe       (oe_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_rd        <= 1'b0;
      fl_wr        <= 1'b0;
      ram_rd       <= 1'b0;
      ram_wr       <= 1'b0;
      standby      <= 1'b1;
      sel_conflict <= 1'b0;
      ram_lo_en    <= 1'b0;
      ram_hi_en    <= 1'b0;
      addr_lsb     <= 1'b0;
      addr_lsb_vld <= 1'b0;
      dq_oe        <= '0;
    end else begin
      fl_rd        <= fl_rd_c;
      fl_wr        <= fl_wr_c;
      ram_rd       <= ram_rd_c;
      ram_wr       <= ram_wr_c;
      standby      <= idle_c;
      sel_conflict <= conflict_c;
      ram_lo_en    <= lo_en_c;
      ram_hi_en    <= hi_en_c;
      addr_lsb     <= lsb_c;
      addr_lsb_vld <= lsb_vld_c;
      dq_oe        <= oe_c;
    end
  end

  // R12: one reader at a time.
  assert_single_reader_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_rd, ram_rd}));

  // R2: flash strobes are exclusive.
  assert_flash_rw_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_rd && fl_wr));

  // R9: a conflict silences everything.
  assert_conflict_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_conflict |-> (dq_oe == '0) && !fl_rd && !fl_wr && !ram_rd && !ram_wr);

  // R7: output enable high in the previous cycle leaves the bus undriven.
  assert_oe_high_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_n) |-> (dq_oe == '0));

  // R8: flash reset low blocks all flash activity one cycle later.
  assert_flash_reset_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fl_rst_n) |-> !fl_rd && !fl_wr && !addr_lsb_vld);

  // R10: in standby no strobe is active.
  assert_standby_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !fl_rd && !fl_wr && !ram_rd && !ram_wr && !sel_conflict);

  // R4: a flash byte-mode read leaves the upper pins undriven.
  assert_byte_upper_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && !$past(fl_word)) |-> (dq_oe[DATA_W-1:LANE_W] == '0));

  // R5: the address bit is only valid in flash byte mode.
  assert_lsb_byte_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_lsb_vld |-> !$past(fl_word) && !$past(fl_ce_n));

endmodule

// File: tb/mcp_bus_decoder_tb_top.sv
`timescale 1ns/1ps
module mcp_bus_decoder_tb_top;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fl_ce_n = 1'b1, ram_sel_n = 1'b1, ram_sel_hi = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic fl_rst_n = 1'b1, fl_word = 1'b1, ram_word = 1'b1, ram_lb_n = 1'b1, ram_ub_n = 1'b1;
  logic dq15_in = 1'b0;
  logic fl_rd, fl_wr, ram_rd, ram_wr, standby, sel_conflict;
  logic ram_lo_en, ram_hi_en, addr_lsb, addr_lsb_vld;
  logic [DW-1:0] dq_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mcp_bus_decoder #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fl_ce_n(fl_ce_n), .ram_sel_n(ram_sel_n),
    .ram_sel_hi(ram_sel_hi), .oe_n(oe_n), .we_n(we_n), .fl_rst_n(fl_rst_n),
    .fl_word(fl_word), .ram_word(ram_word), .ram_lb_n(ram_lb_n), .ram_ub_n(ram_ub_n),
    .dq15_in(dq15_in), .fl_rd(fl_rd), .fl_wr(fl_wr), .ram_rd(ram_rd), .ram_wr(ram_wr),
    .standby(standby), .sel_conflict(sel_conflict), .ram_lo_en(ram_lo_en),
    .ram_hi_en(ram_hi_en), .addr_lsb(addr_lsb), .addr_lsb_vld(addr_lsb_vld), .dq_oe(dq_oe)
  );

  typedef struct packed {
    logic frd, fwr, rrd, rwr, sb, cf, lo, hi, lsb, vld;
    logic [DW-1:0] oe;
  } exp_t;

  // Pin vector order: [10]fl_ce_n [9]ram_sel_n [8]ram_sel_hi [7]oe_n [6]we_n
  // [5]fl_rst_n [4]fl_word [3]ram_word [2]ram_lb_n [1]ram_ub_n [0]dq15_in
  function automatic exp_t model(input logic [10:0] v);
    exp_t e = '0;
    bit flash_on = (v[10] == 1'b0);
    bit ram_on   = (v[9] == 1'b0) && (v[8] == 1'b1);
    bit reading  = (v[7] == 1'b0) && (v[6] == 1'b1);
    if (flash_on && ram_on) begin
      e.cf = 1;
    end else if (!flash_on && !ram_on) begin
      e.sb = 1;
    end else if (flash_on) begin
      if (v[5]) begin
        e.frd = reading;
        e.fwr = (v[6] == 1'b0) && (v[7] == 1'b1);
        if (!v[4]) begin e.vld = 1; e.lsb = v[0]; end
        if (reading)
          for (int i = 0; i < DW; i++) e.oe[i] = (i < DW/2) ? 1'b1 : v[4];
      end
    end else begin
      e.rrd = reading;
      e.rwr = (v[6] == 1'b0);
      if (v[3]) begin e.lo = !v[2]; e.hi = !v[1]; end
      else      begin e.lo = 1; e.hi = 0; end
      if (reading)
        for (int i = 0; i < DW; i++) e.oe[i] = (i < DW/2) ? e.lo : e.hi;
    end
    return e;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [10:0] v);
    {fl_ce_n, ram_sel_n, ram_sel_hi, oe_n, we_n, fl_rst_n, fl_word, ram_word,
     ram_lb_n, ram_ub_n, dq15_in} = v;
  endtask

  task automatic compare(input exp_t e);
    chk("R1", "fl_rd", 32'(fl_rd), 32'(e.frd));
    chk("R2", "fl_wr", 32'(fl_wr), 32'(e.fwr));
    chk("R3", "ram_rd", 32'(ram_rd), 32'(e.rrd));
    chk("R3", "ram_wr", 32'(ram_wr), 32'(e.rwr));
    chk("R10", "standby", 32'(standby), 32'(e.sb));
    chk("R9", "sel_conflict", 32'(sel_conflict), 32'(e.cf));
    chk("R6", "ram lane enables", 32'({ram_lo_en, ram_hi_en}), 32'({e.lo, e.hi}));
    chk("R5", "addr lsb", 32'({addr_lsb_vld, addr_lsb}), 32'({e.vld, e.lsb}));
    chk("R4 R6 R7", "dq_oe", 32'(dq_oe), 32'(e.oe));
    chk("R12", "reader overlap", 32'(fl_rd & ram_rd), 32'(0));
  endtask

  // Apply at a falling edge; outputs are judged one full cycle later (R11).
  task automatic step(input logic [10:0] v);
    exp_t e = model(v);
    @(negedge clk);
    drive(v);
    @(negedge clk);
    compare(e);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R11: reset values.
    drive(11'b0_1_0_0_1_1_1_1_1_1_0);
    repeat (3) @(negedge clk);
    chk("R11", "reset strobes", 32'({fl_rd, fl_wr, ram_rd, ram_wr, sel_conflict}), 32'(0));
    chk("R11", "reset standby", 32'(standby), 32'(1));
    chk("R11", "reset dq_oe", 32'(dq_oe), 32'(0));
    @(negedge clk);
    rst_n = 1'b1;

    // R11: one-cycle latency for a flash word read.
    @(negedge clk);
    drive(11'b0_1_0_0_1_1_1_1_1_1_0);
    @(negedge clk);
    chk("R1", "flash word read", 32'(fl_rd), 32'(1));
    drive(11'b1_1_0_1_1_1_1_1_1_1_0);
    #1;
    chk("R11", "no change before edge", 32'(fl_rd), 32'(1));
    @(negedge clk);
    chk("R11", "change after edge", 32'(fl_rd), 32'(0));

    // Directed corners.
    step(11'b0_1_0_0_1_1_0_1_1_1_1);  // flash byte read, dq15=1
    chk("R5", "byte lsb", 32'({addr_lsb_vld, addr_lsb}), 32'(2'b11));
    chk("R4", "byte lanes", 32'(dq_oe), 32'(16'h00FF));
    step(11'b0_1_0_0_1_0_0_1_1_1_1);  // same with flash reset low
    chk("R8", "reset blocks read", 32'({fl_rd, addr_lsb_vld, dq_oe}), 32'(0));
    step(11'b0_0_1_0_1_0_1_1_0_0_0);  // conflict plus flash reset
    chk("R9", "conflict flag", 32'(sel_conflict), 32'(1));
    chk("R9", "conflict bus", 32'({dq_oe, ram_rd}), 32'(0));
    step(11'b1_0_1_0_1_1_1_1_0_1_0);  // RAM word read, low byte only
    chk("R6", "ram low only", 32'(dq_oe), 32'(16'h00FF));
    step(11'b1_0_1_0_1_1_1_0_1_1_0);  // RAM byte mode, enables off
    chk("R6", "ram byte ignores enables", 32'({ram_lo_en, ram_hi_en}), 32'(2'b10));
    step(11'b1_0_0_0_1_1_1_1_0_0_0);  // RAM high select missing
    chk("R10", "ram not selected", 32'({standby, ram_rd}), 32'(2'b10));
    step(11'b1_0_1_0_0_1_1_1_0_0_0);  // RAM write with oe low
    chk("R3", "ram write any oe", 32'({ram_wr, ram_rd}), 32'(2'b10));

    // Exhaustive sweep against the reference model.
    for (int k = 0; k < 2048; k++) step(11'(k));
    for (int k = 2047; k >= 0; k -= 7) step(11'(k));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule